// File: doc/BRIEF.md
# Buffered Addressed Parallel Slave Port

This block lets an external bus master reach four incoming and four outgoing byte buffers over an 8-bit asynchronous parallel interface. The interface has a chip select, a read strobe, a write strobe and two address bits. The three control inputs are active high. They are brought into the local clock domain through a two-flop synchronizer. A byte transfer takes effect when its strobe ends: a write captures the data byte, and a read marks the byte as consumed.

Local logic sees the buffers as two 16-bit input holding registers and two 16-bit output holding registers. Byte b of a direction sits in register b/2. An even b uses bits [7:0] and an odd b uses bits [15:8].

Two ways of choosing the byte are available:
- In addressed mode the external address lines pick the byte.
- In auto mode a separate write pointer and read pointer each step through bytes 0..3 and wrap.

Each byte has its own status flag: full for incoming bytes and empty for outgoing bytes. Two sticky error flags record overflow and underflow. While the port is disabled, the buffer data and all status are held. Enabling the port clears the status and both pointers.

Top module: `par_slave_buf`

## Requirements
- R1: After reset, `in_full`, `out_empty`, `ovf`, `unf` and `ext_doe` are all 0, and both holding-register outputs read 0.
- R2: In addressed mode (`addr_mode`=1), an external write stores `ext_din` into input byte `ext_addr`. That byte appears at bits [8*(b%2)+7 : 8*(b%2)] of `in_data0` (b=0,1) or `in_data1` (b=2,3).
- R3: In auto mode (`addr_mode`=0), each external write goes to the byte named by the write pointer, and the pointer then steps 0,1,2,3,0.
- R4: An external read drives the selected output byte on `ext_dout`. The byte is chosen by `ext_addr` in addressed mode, or by a read pointer that steps 0,1,2,3,0 in auto mode.
- R5: An external write sets `in_full[b]` for the written byte. A one-cycle pulse on `in_rd[k]` clears `in_full[2k]` and `in_full[2k+1]`.
- R6: An external read sets `out_empty[b]` for the byte read. A one-cycle pulse on `out_wr[k]` loads `out_wdata` into output register k and clears `out_empty[2k]` and `out_empty[2k+1]`.
- R7: An external write to a byte whose `in_full` bit is already 1 sets `ovf`, which then stays 1. The new byte still replaces the old one.
- R8: An external read of a byte whose `out_empty` bit is already 1 sets `unf`, which then stays 1.
- R9: While `en`=0, external strobes change no data, flag or pointer, and `ext_doe` stays 0. Existing data and status remain readable.
- R10: A rising `en` clears `in_full`, `out_empty`, `ovf`, `unf` and both pointers. The buffer data is kept.
- R11: A transfer takes effect only at the end of its strobe. While the strobe is still held, no status flag changes.
- R12: `ext_doe` is 1 exactly while `en`, `ext_cs` and `ext_rd` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Port enable |
| addr_mode | input | 1 | 1 = external address picks the byte, 0 = auto pointers |
| ext_cs | input | 1 | External chip select, active high |
| ext_rd | input | 1 | External read strobe, active high |
| ext_wr | input | 1 | External write strobe, active high |
| ext_addr | input | 2 | External byte address |
| ext_din | input | DW | External write data |
| ext_dout | output | DW | External read data |
| ext_doe | output | 1 | Output enable for `ext_dout` |
| in_rd | input | 2 | Local read pulse, one bit per input holding register |
| in_data0 | output | 2*DW | Input holding register 0 (bytes 1:0) |
| in_data1 | output | 2*DW | Input holding register 1 (bytes 3:2) |
| out_wr | input | 2 | Local write pulse, one bit per output holding register |
| out_wdata | input | 2*DW | Local write data for the output holding registers |
| in_full | output | 4 | Per-byte full flags of the input buffer |
| out_empty | output | 4 | Per-byte empty flags of the output buffer |
| ovf | output | 1 | Sticky overflow flag |
| unf | output | 1 | Sticky underflow flag |

## Verification
Directed sequences come first:
- Addressed writes reach every byte lane. This separates a wrong lane placement from a wrong index.
- Five back-to-back auto writes and five auto reads show that each pointer wraps. The fifth access lands on a full or empty byte, which tells a wrapping pointer apart from one that saturates, and also sets `ovf` or `unf`.

A disable/enable cycle that includes strobes while disabled shows which state is held and which is cleared. Seeded random mixes of external and local accesses, mode switches and enable toggles follow. They are compared against a bench model, which exposes wrong priorities between local clears and external sets, and pointers that drift across mode changes.

// File: rtl/par_slave_buf.sv
module par_slave_buf #(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          addr_mode,
  input  logic          ext_cs,
  input  logic          ext_rd,
  input  logic          ext_wr,
  input  logic [1:0]    ext_addr,
  input  logic [DW-1:0] ext_din,
  output logic [DW-1:0] ext_dout,
  output logic          ext_doe,
  input  logic [1:0]    in_rd,
  output logic [2*DW-1:0] in_data0,
  output logic [2*DW-1:0] in_data1,
  input  logic [1:0]    out_wr,
  input  logic [2*DW-1:0] out_wdata,
  output logic [3:0]    in_full,
  output logic [3:0]    out_empty,
  output logic          ovf,
  output logic          unf
);
  localparam int NB = 4;
  localparam int AW = $clog2(NB);

  logic [DW-1:0] ibuf [NB];
  logic [DW-1:0] obuf [NB];
  logic [SYNC:0] wr_sh, rd_sh;
  logic [AW-1:0] wptr, rptr, widx, ridx;
  logic          en_q, en_rise, wr_end, rd_end;
  logic [3:0]    full_n, empty_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_sh <= '0;
      rd_sh <= '0;
      en_q  <= 1'b0;
    end else begin
      wr_sh <= {wr_sh[SYNC-1:0], ext_cs & ext_wr};
      rd_sh <= {rd_sh[SYNC-1:0], ext_cs & ext_rd};
      en_q  <= en;
    end

  assign en_rise = en & ~en_q;
  assign wr_end  = en & en_q & wr_sh[SYNC] & ~wr_sh[SYNC-1];
  assign rd_end  = en & en_q & rd_sh[SYNC] & ~rd_sh[SYNC-1];
  assign widx    = addr_mode ? ext_addr : wptr;
  assign ridx    = addr_mode ? ext_addr : rptr;

  assign ext_doe  = en & ext_cs & ext_rd;
  assign ext_dout = obuf[ridx];
  assign in_data0 = {ibuf[1], ibuf[0]};
  assign in_data1 = {ibuf[3], ibuf[2]};

  always_comb begin
    full_n  = in_full;
    empty_n = out_empty;
    if (in_rd[0])  full_n[1:0]  = 2'b00;
    if (in_rd[1])  full_n[3:2]  = 2'b00;
    if (out_wr[0]) empty_n[1:0] = 2'b00;
    if (out_wr[1]) empty_n[3:2] = 2'b00;
    if (wr_end)    full_n[widx]  = 1'b1;
    if (rd_end)    empty_n[ridx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_full   <= '0;
      out_empty <= '0;
      ovf       <= 1'b0;
      unf       <= 1'b0;
      wptr      <= '0;
      rptr      <= '0;
    end else if (en_rise) begin
      in_full   <= '0;
      out_empty <= '0;
      ovf       <= 1'b0;
      unf       <= 1'b0;
      wptr      <= '0;
      rptr      <= '0;
    end else begin
      in_full   <= full_n;
      out_empty <= empty_n;
      if (wr_end && in_full[widx])   ovf <= 1'b1;
      if (rd_end && out_empty[ridx]) unf <= 1'b1;
      if (wr_end && !addr_mode) wptr <= wptr + 1'b1;
      if (rd_end && !addr_mode) rptr <= rptr + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin
        ibuf[i] <= '0;
        obuf[i] <= '0;
      end
    end else begin
      if (wr_end) ibuf[widx] <= ext_din;
      for (int k = 0; k < NB/2; k++)
        if (out_wr[k]) begin
          obuf[2*k]   <= out_wdata[DW-1:0];
          obuf[2*k+1] <= out_wdata[2*DW-1:DW];
        end
    end

  // R3
  auto_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_end && !addr_mode) |=> wptr == $past(wptr) + 1'b1);
  // R5
  full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_end |=> in_full[$past(widx)]);
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !en_rise) |=> ovf);
  // R8
  unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unf && !en_rise) |=> unf);
  // R9
  dis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(wptr) && $stable(rptr) && !$rose(ovf) && !$rose(unf)));
  // R10
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (in_full == 4'd0 && out_empty == 4'd0 && !ovf && !unf));
endmodule

// File: tb/par_slave_buf_bench.sv
module par_slave_buf_bench;
  logic clk = 0, rst_n = 0, en = 0, addr_mode = 0;
  logic ext_cs = 0, ext_rd = 0, ext_wr = 0;
  logic [1:0] ext_addr = 0;
  logic [7:0] ext_din = 0, ext_dout;
  logic ext_doe;
  logic [1:0] in_rd = 0, out_wr = 0;
  logic [15:0] in_data0, in_data1, out_wdata = 0;
  logic [3:0] in_full, out_empty;
  logic ovf, unf;

  int total = 0, bad = 0;
  logic [7:0] m_in [4];
  logic [7:0] m_out [4];
  logic [3:0] m_full = 0, m_empty = 0;
  logic m_ovf = 0, m_unf = 0, m_en = 0;
  logic [1:0] m_wp = 0, m_rp = 0;

  par_slave_buf u_par_slave_buf (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_reg(int k);
    return {m_in[2*k+1], m_in[2*k]};
  endfunction

  task automatic clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(string req);
    chk({req, " in_data0"}, in_data0, exp_reg(0));
    chk({req, " in_data1"}, in_data1, exp_reg(1));
    chk({req, " in_full"}, in_full, m_full);
    chk({req, " out_empty"}, out_empty, m_empty);
    chk({req, " ovf"}, ovf, m_ovf);
    chk({req, " unf"}, unf, m_unf);
  endtask

  task automatic ext_write(logic [1:0] a, logic [7:0] d);
    logic [1:0] idx;
    idx = addr_mode ? a : m_wp;
    ext_addr = a; ext_din = d; ext_cs = 1; ext_wr = 1;
    clks(5);
    chk("R11 full held during strobe", in_full, m_full);
    ext_wr = 0;
    clks(5);
    ext_cs = 0;
    if (m_en) begin
      if (m_full[idx]) m_ovf = 1;
      m_in[idx] = d;
      m_full[idx] = 1;
      if (!addr_mode) m_wp++;
    end
    clks(1);
    check_all("R2 R3 R5 R7 R9 write");
  endtask

  task automatic ext_read(logic [1:0] a);
    logic [1:0] idx;
    idx = addr_mode ? a : m_rp;
    ext_addr = a; ext_cs = 1; ext_rd = 1;
    clks(5);
    chk("R12 doe during read", ext_doe, m_en);
    if (m_en) chk("R4 read data", ext_dout, m_out[idx]);
    chk("R11 empty held during strobe", out_empty, m_empty);
    ext_rd = 0;
    clks(1);
    chk("R12 doe after read", ext_doe, 0);
    clks(4);
    ext_cs = 0;
    if (m_en) begin
      if (m_empty[idx]) m_unf = 1;
      m_empty[idx] = 1;
      if (!addr_mode) m_rp++;
    end
    clks(1);
    check_all("R4 R6 R8 R9 read");
  endtask

  task automatic loc_read(int k);
    in_rd[k] = 1; clks(1); in_rd = 0; clks(1);
    m_full[2*k] = 0; m_full[2*k+1] = 0;
    check_all("R5 local read");
  endtask

  task automatic loc_write(int k, logic [15:0] d);
    out_wdata = d; out_wr[k] = 1; clks(1); out_wr = 0; clks(1);
    m_out[2*k] = d[7:0]; m_out[2*k+1] = d[15:8];
    m_empty[2*k] = 0; m_empty[2*k+1] = 0;
    check_all("R6 local write");
  endtask

  task automatic set_en(logic v);
    en = v; clks(2);
    if (v && !m_en) begin
      m_full = 0; m_empty = 0; m_ovf = 0; m_unf = 0; m_wp = 0; m_rp = 0;
    end
    m_en = v;
    check_all("R10 enable");
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_in[i] = 0; m_out[i] = 0; end
    void'($urandom(32'd4242));
    clks(3);
    rst_n = 1;
    clks(1);
    check_all("R1 reset");
    chk("R1 doe", ext_doe, 0);
    set_en(1);
    addr_mode = 1;
    for (int b = 0; b < 4; b++) ext_write(2'(3 - b), 8'h10 + 8'(b));
    for (int k = 0; k < 2; k++) loc_read(k);
    addr_mode = 0;
    for (int b = 0; b < 5; b++) ext_write(2'd0, 8'hA0 + 8'(b));
    chk("R7 overflow after wrap", ovf, 1);
    loc_write(0, 16'h2211);
    loc_write(1, 16'h4433);
    for (int b = 0; b < 5; b++) ext_read(2'd3);
    chk("R8 underflow after wrap", unf, 1);
    set_en(0);
    ext_write(2'd1, 8'h5A);
    ext_read(2'd1);
    chk("R9 data kept while disabled", in_data0, exp_reg(0));
    set_en(1);
    chk("R10 ovf cleared", ovf, 0);
    for (int n = 0; n < 250; n++) begin
      case ($urandom % 8)
        0, 1: ext_write(2'($urandom), 8'($urandom));
        2, 3: ext_read(2'($urandom));
        4: loc_read(int'($urandom % 2));
        5: loc_write(int'($urandom % 2), 16'($urandom));
        6: addr_mode = ~addr_mode;
        default: set_en(($urandom % 4) != 0);
      endcase
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule